// File: doc/BRIEF.md
# Low-pin-count firmware bus target front-end

This block sits on the target side of a 4-bit multiplexed low-pin-count host bus. It watches an active-low frame strobe and the nibble bus and remembers the nibble present on the last clock the strobe is low. That nibble, the START code, selects one of two cycle families. The first is a standard memory cycle, which carries a direction nibble and then eight address nibbles. The second is a firmware-memory cycle, which carries a device-select nibble, seven address nibbles and a size nibble.

Once the block has collected the header and, for writes, the data byte, it raises a one-byte request on a simple memory-side port and holds it until the memory answers. It then drives the sync nibbles and, for reads, the data byte, and it hands the bus back after a closing turnaround. A low frame strobe at any point abandons the current transfer, and the nibble on that clock becomes a candidate START for the next cycle. Cycles that are not meant for this target are ignored, and the bus stays released for them.

Top module: `lfb_target`

## Requirements
- R1: The START code is the bus nibble sampled on the last clock with `frm_n` low. Earlier nibbles of a strobe held low for several clocks have no effect.
- R2: START 4'b0000 begins a standard memory cycle. The next nibble is 4'b010x for a read or 4'b011x for a write (bit 1 high means write). Any other value there makes the cycle ignored. Eight address nibbles follow, most significant first, and the low 19 bits appear on `mem_addr`.
- R3: START 4'b1101 is a firmware read and START 4'b1110 is a firmware write. The next nibble must equal `dev_id`, then seven address nibbles follow (most significant first), then a size nibble that must be 4'b0000. If either test fails, no request is made and the bus is never driven.
- R4: Any other START value produces no memory request and no bus drive until the next frame.
- R5: Write data arrives low nibble first on `mem_wdata`. `mem_req` rises on the clock after the last host nibble. It stays high, with address, direction and data stable, until it is sampled together with `mem_ready`, and it drops on the next clock.
- R6: After the last host nibble the bus stays released for two clocks. The target then drives 4'b0101 while the memory has not answered, and 4'b0000 once it has. A memory answering within the two turnaround clocks gives no wait nibble, and a memory latency of L clocks gives max(0, L-1) wait nibbles.
- R7: For a read, the 4'b0000 sync is followed by the low nibble and then the high nibble of the read byte, then one clock of 4'b1111, then the bus is released.
- R8: For a write, the 4'b0000 sync is followed by one clock of 4'b1111, then the bus is released.
- R9: When `frm_n` is low at a clock edge, the target releases the bus and drops `mem_req` on the next clock, whatever the cycle phase. A cycle whose START follows at once is served normally.
- R10: `idle` is high when `frm_n` is high and no claimed cycle or request is in progress, including while an unclaimed cycle is being skipped. While `idle` is high the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_n | input | 1 | Active-low frame/abort strobe from the host |
| bus_in | input | 4 | Nibble bus as seen by the target |
| bus_out | output | 4 | Nibble the target drives |
| bus_drv | output | 1 | High while `bus_out` should be driven onto the bus |
| dev_id | input | 4 | Strapped device-select value for firmware cycles |
| mem_req | output | 1 | One-byte access request to the memory side |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, taken when `mem_ready` is seen |
| mem_ready | input | 1 | Memory completes the pending request |
| idle | output | 1 | Standby indication |

## Verification
A host abort and the completion of the memory handshake can land on the same clock edge. In that case the abort must win: the target must not go on to drive the done sync or read data, and it must not repeat the request. The bench provokes this by giving the memory model a two-clock latency, so that it raises `mem_ready` on the very clock where the host pulls `frm_n` low during the first sync nibble. It judges the outcome by the released bus and the dropped request on the next clock, by the idle flag, and by a following cycle whose request and data match the scoreboard with nothing extra queued. A slow-memory abort during wait syncs and an abort during the address phase cover the neighbouring orderings.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

   localparam logic [3:0] START_MEM   = 4'b0000;
   localparam logic [3:0] START_FW_RD = 4'b1101;
   localparam logic [3:0] START_FW_WR = 4'b1110;
   localparam logic [3:0] SYNC_WAIT   = 4'b0101;
   localparam logic [3:0] SYNC_DONE   = 4'b0000;
   localparam logic [3:0] NIB_TURN    = 4'b1111;

   typedef enum logic [1:0] {
      FAM_NONE,
      FAM_MEM,
      FAM_FW_RD,
      FAM_FW_WR
   } fam_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SIZE,
      ST_WDAT,
      ST_TAR0,
      ST_TAR1,
      ST_SYNC,
      ST_RDAT,
      ST_TAR2,
      ST_TAR3,
      ST_SKIP
   } st_t;

endpackage

// File: rtl/lfb_start_dec.sv
module lfb_start_dec
   import lfb_pkg::*;
(
   input  logic [3:0] start_nib,
   input  logic [3:0] hdr_nib,
   input  logic [3:0] dev_id,
   output fam_t       fam,
   output logic       hdr_ok,
   output logic       hdr_we
);

   always_comb begin
      fam    = FAM_NONE;
      hdr_ok = 1'b0;
      hdr_we = 1'b0;
      case (start_nib)
         START_MEM: begin
            fam    = FAM_MEM;
            hdr_ok = (hdr_nib[3:2] == 2'b01);
            hdr_we = hdr_nib[1];
         end
         START_FW_RD: begin
            fam    = FAM_FW_RD;
            hdr_ok = (hdr_nib == dev_id);
            hdr_we = 1'b0;
         end
         START_FW_WR: begin
            fam    = FAM_FW_WR;
            hdr_ok = (hdr_nib == dev_id);
            hdr_we = 1'b1;
         end
         default: begin
            fam    = FAM_NONE;
            hdr_ok = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/lfb_capture.sv
module lfb_capture #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8,
   parameter int LANE_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        nib,
   input  logic              addr_shift,
   input  logic              wr_en,
   input  logic [LANE_W-1:0] wr_lane,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);

   localparam int NIBS = DATA_W / 4;

   logic [ADDR_W-1:0] addr_q;

   // Upper nibbles beyond ADDR_W simply fall off the top.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (addr_shift) begin
         addr_q <= {addr_q[ADDR_W-5:0], nib};
      end
   end

   assign addr = addr_q;

   for (genvar g = 0; g < NIBS; g++) begin : g_lane
      logic [3:0] lane_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_r <= '0;
         end else if (wr_en && (wr_lane == LANE_W'(g))) begin
            lane_r <= nib;
         end
      end
      assign wdata[g*4 +: 4] = lane_r;
   end

   AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_lane) < NIBS)) else $error("write lane out of range"); // R5

endmodule

// File: rtl/lfb_target.sv
module lfb_target
   import lfb_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 8,
   parameter int MEM_NIBS = 8,
   parameter int FW_NIBS  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_n,
   input  logic [3:0]        bus_in,
   output logic [3:0]        bus_out,
   output logic              bus_drv,
   input  logic [3:0]        dev_id,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              idle
);

   localparam int DATA_NIBS = DATA_W / 4;
   localparam int LANE_W    = (DATA_NIBS > 1) ? $clog2(DATA_NIBS) : 1;
   localparam int MAX_NIBS  = (MEM_NIBS > FW_NIBS) ? MEM_NIBS : FW_NIBS;
   localparam int CNT_W     = $clog2(MAX_NIBS);
   localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(DATA_NIBS - 1);
   localparam logic [CNT_W-1:0]  MEM_LAST  = CNT_W'(MEM_NIBS - 1);
   localparam logic [CNT_W-1:0]  FW_LAST   = CNT_W'(FW_NIBS - 1);

   if (DATA_W % 4 != 0 || DATA_W < 4) begin : g_bad_data
      $error("DATA_W must be a positive multiple of 4");
   end
   if (ADDR_W < 5 || ADDR_W > 4 * FW_NIBS || ADDR_W > 4 * MEM_NIBS) begin : g_bad_addr
      $error("ADDR_W must fit in both address fields and exceed one nibble");
   end
   if (MAX_NIBS < 2) begin : g_bad_nibs
      $error("address fields need at least two nibbles");
   end

   st_t               st_q;
   logic [3:0]        start_q;
   logic              armed_q;
   logic              we_q;
   logic              fw_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [LANE_W-1:0] lane_q;
   logic              req_q;
   logic              done_q;
   logic [DATA_W-1:0] rdata_q;

   fam_t fam;
   logic hdr_ok;
   logic hdr_we;

   lfb_start_dec u_dec (
      .start_nib (start_q),
      .hdr_nib   (bus_in),
      .dev_id    (dev_id),
      .fam       (fam),
      .hdr_ok    (hdr_ok),
      .hdr_we    (hdr_we)
   );

   logic addr_shift;
   logic wr_en;

   assign addr_shift = frm_n && (st_q == ST_ADDR);
   assign wr_en      = frm_n && (st_q == ST_WDAT);

   lfb_capture #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANE_W (LANE_W)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .nib        (bus_in),
      .addr_shift (addr_shift),
      .wr_en      (wr_en),
      .wr_lane    (lane_q),
      .addr       (mem_addr),
      .wdata      (mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         start_q <= NIB_TURN;
         armed_q <= 1'b0;
         we_q    <= 1'b0;
         fw_q    <= 1'b0;
         cnt_q   <= '0;
         lane_q  <= '0;
         req_q   <= 1'b0;
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else if (!frm_n) begin
         // Abort and START capture share one path: the last low nibble wins.
         start_q <= bus_in;
         armed_q <= 1'b1;
         st_q    <= ST_IDLE;
         req_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         if (req_q && mem_ready) begin
            req_q   <= 1'b0;
            done_q  <= 1'b1;
            rdata_q <= mem_rdata;
         end
         case (st_q)
            ST_IDLE: begin
               if (armed_q) begin
                  armed_q <= 1'b0;
                  done_q  <= 1'b0;
                  if (hdr_ok) begin
                     we_q  <= hdr_we;
                     fw_q  <= (fam != FAM_MEM);
                     cnt_q <= (fam == FAM_MEM) ? MEM_LAST : FW_LAST;
                     st_q  <= ST_ADDR;
                  end else begin
                     st_q <= ST_SKIP;
                  end
               end
            end
            ST_ADDR: begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == '0) begin
                  lane_q <= '0;
                  if (fw_q) begin
                     st_q <= ST_SIZE;
                  end else if (we_q) begin
                     st_q <= ST_WDAT;
                  end else begin
                     st_q  <= ST_TAR0;
                     req_q <= 1'b1;
                  end
               end
            end
            ST_SIZE: begin
               if (bus_in != 4'b0000) begin
                  st_q <= ST_SKIP;
               end else if (we_q) begin
                  st_q <= ST_WDAT;
               end else begin
                  st_q  <= ST_TAR0;
                  req_q <= 1'b1;
               end
            end
            ST_WDAT: begin
               lane_q <= lane_q + 1'b1;
               if (lane_q == LAST_LANE) begin
                  st_q  <= ST_TAR0;
                  req_q <= 1'b1;
               end
            end
            ST_TAR0: st_q <= ST_TAR1;
            ST_TAR1: st_q <= ST_SYNC;
            ST_SYNC: begin
               if (done_q) begin
                  lane_q <= '0;
                  st_q   <= we_q ? ST_TAR2 : ST_RDAT;
               end
            end
            ST_RDAT: begin
               lane_q <= lane_q + 1'b1;
               if (lane_q == LAST_LANE) begin
                  st_q <= ST_TAR2;
               end
            end
            ST_TAR2: st_q <= ST_TAR3;
            ST_TAR3: st_q <= ST_IDLE;
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_drv = 1'b0;
      bus_out = NIB_TURN;
      case (st_q)
         ST_SYNC: begin
            bus_drv = 1'b1;
            bus_out = done_q ? SYNC_DONE : SYNC_WAIT;
         end
         ST_RDAT: begin
            bus_drv = 1'b1;
            bus_out = rdata_q[{lane_q, 2'b00} +: 4];
         end
         ST_TAR2: begin
            bus_drv = 1'b1;
            bus_out = NIB_TURN;
         end
         default: ;
      endcase
   end

   assign mem_req = req_q;
   assign mem_we  = we_q;
   assign idle    = frm_n && !req_q &&
                    (((st_q == ST_IDLE) && !armed_q) || (st_q == ST_SKIP));

   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_n |=> (!bus_drv && !mem_req)) else $error("abort not honoured"); // R9

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready && frm_n) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
      else $error("request not held"); // R5

   AST_REQ_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready) |=> !mem_req) else $error("request not retired"); // R5

   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drv && bus_out == SYNC_WAIT && frm_n) |=> bus_drv)
      else $error("bus released during wait"); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!bus_drv && !mem_req)) else $error("activity while idle"); // R10

endmodule

// File: tb/sim_lfb_target.sv
`timescale 1ns/1ps
module sim_lfb_target;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_n = 1'b1;
   logic [3:0] bus_in = 4'hF;
   logic [3:0] dev_id = 4'h6;
   logic [3:0] bus_out;
   logic       bus_drv;
   logic       mem_req;
   logic       mem_we;
   logic [18:0] mem_addr;
   logic [7:0] mem_wdata;
   logic [7:0] mem_rdata;
   logic       mem_ready = 1'b0;
   logic       idle;

   always #10 clk = ~clk;

   lfb_target u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_n     (frm_n),
      .bus_in    (bus_in),
      .bus_out   (bus_out),
      .bus_drv   (bus_drv),
      .dev_id    (dev_id),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready),
      .idle      (idle)
   );

   assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // scoreboard of expected memory requests
   logic        q_we[$];
   logic [18:0] q_addr[$];
   logic [7:0]  q_wd[$];
   string       q_tag[$];

   logic       s_drv;
   logic [3:0] s_out;
   logic       s_idle;
   logic       s_req;
   int lat = 0;
   int mcnt = 0;
   bit seen = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic expect_req(input logic we, input logic [18:0] a,
                             input logic [7:0] wd, input string tag);
      q_we.push_back(we);
      q_addr.push_back(a);
      q_wd.push_back(wd);
      q_tag.push_back(tag);
   endtask

   // memory model and monitor: compares each new request against the queue
   always @(negedge clk) begin
      if (!mem_req) begin
         mem_ready = 1'b0;
         mcnt = 0;
         seen = 0;
      end else begin
         if (!seen) begin
            seen = 1;
            if (q_we.size() == 0) begin
               chk(0, "R4", "unexpected request addr", int'(mem_addr), 0);
            end else begin
               logic        e_we;
               logic [18:0] e_a;
               logic [7:0]  e_d;
               string       e_t;
               e_we = q_we.pop_front();
               e_a  = q_addr.pop_front();
               e_d  = q_wd.pop_front();
               e_t  = q_tag.pop_front();
               chk(mem_we == e_we, e_t, "request direction", int'(mem_we), int'(e_we));
               chk(mem_addr == e_a, e_t, "request address", int'(mem_addr), int'(e_a));
               if (e_we) chk(mem_wdata == e_d, "R5", "write data", int'(mem_wdata), int'(e_d));
            end
         end
         if (!mem_ready) begin
            if (mcnt >= lat) mem_ready = 1'b1;
            else mcnt++;
         end
      end
   end

   task automatic step(input logic f, input logic [3:0] n);
      @(negedge clk);
      s_drv  = bus_drv;
      s_out  = bus_out;
      s_idle = idle;
      s_req  = mem_req;
      frm_n  = f;
      bus_in = n;
   endtask

   task automatic send_hdr(input logic [3:0] st, input logic [3:0] f1,
                           input int nad, input logic [31:0] ab);
      step(1'b0, st);
      step(1'b1, f1);
      for (int i = 0; i < nad; i++) step(1'b1, ab[4*(nad-1-i) +: 4]);
   endtask

   task automatic do_cycle(input int npre, input logic [3:0] st, input logic [3:0] f1,
                           input int nad, input logic [31:0] ab, input bit hs,
                           input logic [3:0] sz, input bit we, input logic [7:0] wd,
                           input bit claim, input string rq);
      int waits;
      int exp_waits;
      logic [7:0] rd;
      if (claim) expect_req(we, ab[18:0], wd, rq);
      for (int i = 0; i < npre; i++) step(1'b0, 4'h7 + 4'(i));
      send_hdr(st, f1, nad, ab);
      if (hs) step(1'b1, sz);
      if (we) begin
         step(1'b1, wd[3:0]);
         step(1'b1, wd[7:4]);
      end
      if (!claim) begin
         for (int i = 0; i < 6; i++) begin
            step(1'b1, 4'hF);
            chk(!s_drv, rq, "bus driven on ignored cycle", int'(s_drv), 0);
         end
         chk(s_idle, "R10", "idle while skipping", int'(s_idle), 1);
         return;
      end
      step(1'b1, 4'hF);
      chk(!s_drv, "R6", "first turnaround driven", int'(s_drv), 0);
      step(1'b1, 4'hF);
      chk(!s_drv, "R6", "second turnaround driven", int'(s_drv), 0);
      waits = 0;
      while (1) begin
         step(1'b1, 4'hF);
         if (s_drv && s_out == 4'b0101 && waits < 64) waits++;
         else break;
      end
      chk(s_drv && s_out == 4'b0000, "R6", "sync done nibble", int'(s_out), 0);
      exp_waits = (lat > 1) ? lat - 1 : 0;
      chk(waits == exp_waits, "R6", "wait nibble count", waits, exp_waits);
      if (!we) begin
         rd = ab[7:0] ^ 8'hA5;
         step(1'b1, 4'hF);
         chk(s_drv && s_out == rd[3:0], "R7", "read low nibble", int'(s_out), int'(rd[3:0]));
         step(1'b1, 4'hF);
         chk(s_drv && s_out == rd[7:4], "R7", "read high nibble", int'(s_out), int'(rd[7:4]));
      end
      step(1'b1, 4'hF);
      chk(s_drv && s_out == 4'hF, we ? "R8" : "R7", "closing turnaround", int'(s_out), 15);
      step(1'b1, 4'hF);
      chk(!s_drv, we ? "R8" : "R7", "bus released", int'(s_drv), 0);
      step(1'b1, 4'hF);
      chk(s_idle, "R10", "idle after cycle", int'(s_idle), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 4'hF);
      step(1'b1, 4'hF);
      chk(s_idle, "R10", "idle after reset", int'(s_idle), 1);
      chk(!s_drv && !s_req, "R10", "quiet after reset", int'(s_drv) + int'(s_req), 0);

      // R2 memory read, memory answers at once
      lat = 0;
      do_cycle(0, 4'b0000, 4'b0100, 8, 32'hFFF2_3456, 0, 4'h0, 0, 8'h00, 1, "R2");
      // R2 / R5 memory write with wait syncs
      lat = 3;
      do_cycle(0, 4'b0000, 4'b0110, 8, 32'h0007_ABCD, 0, 4'h0, 1, 8'h3C, 1, "R2");
      // R1 strobe held low three clocks before a firmware read
      lat = 1;
      do_cycle(2, 4'b1101, 4'h6, 7, 32'h0005_1234, 1, 4'h0, 0, 8'h00, 1, "R1");
      // R3 firmware write, long latency
      lat = 5;
      do_cycle(0, 4'b1110, 4'h6, 7, 32'h0123_4567, 1, 4'h0, 1, 8'hE1, 1, "R3");
      // R3 wrong device select, and non-zero size
      lat = 0;
      do_cycle(0, 4'b1101, 4'h3, 7, 32'h0000_1111, 1, 4'h0, 0, 8'h00, 0, "R3");
      do_cycle(0, 4'b1101, 4'h6, 7, 32'h0000_2222, 1, 4'h1, 0, 8'h00, 0, "R3");
      // R4 unknown START
      do_cycle(0, 4'b0101, 4'h4, 8, 32'h1234_5678, 0, 4'h0, 0, 8'h00, 0, "R4");
      // R2 invalid direction nibble
      do_cycle(0, 4'b0000, 4'b1000, 8, 32'h0000_3333, 0, 4'h0, 0, 8'h00, 0, "R2");

      // R9 abort during the address phase; the abort nibble is the next START
      step(1'b0, 4'b0000);
      step(1'b1, 4'b0100);
      step(1'b1, 4'h1);
      step(1'b1, 4'h2);
      do_cycle(0, 4'b1110, 4'h6, 7, 32'h0004_5A5A, 1, 4'h0, 1, 8'h96, 1, "R9");

      // R9 abort during wait syncs with a slow memory
      lat = 10;
      expect_req(1'b0, 19'h1_1111, 8'h00, "R9");
      send_hdr(4'b0000, 4'b0100, 8, 32'h0001_1111);
      step(1'b1, 4'hF);
      step(1'b1, 4'hF);
      step(1'b1, 4'hF);
      chk(s_drv && s_out == 4'b0101, "R6", "wait sync before abort", int'(s_out), 5);
      step(1'b0, 4'hF);
      step(1'b1, 4'hF);
      chk(!s_drv && !s_req, "R9", "released after abort", int'(s_drv) + int'(s_req), 0);
      step(1'b1, 4'hF);
      chk(s_idle, "R10", "idle after aborted cycle", int'(s_idle), 1);

      // R9 abort on the same edge as memory completion
      lat = 2;
      expect_req(1'b0, 19'h2_2222, 8'h00, "R9");
      send_hdr(4'b0000, 4'b0100, 8, 32'h0002_2222);
      step(1'b1, 4'hF);
      step(1'b1, 4'hF);
      step(1'b0, 4'hF);
      chk(s_drv && s_out == 4'b0101, "R6", "wait sync at abort edge", int'(s_out), 5);
      step(1'b1, 4'hF);
      chk(!s_drv && !s_req, "R9", "abort wins over ready", int'(s_drv) + int'(s_req), 0);
      step(1'b1, 4'hF);
      chk(!s_drv, "R9", "no data after abort", int'(s_drv), 0);
      chk(s_idle, "R10", "idle after abort race", int'(s_idle), 1);
      lat = 0;
      do_cycle(0, 4'b0000, 4'b0100, 8, 32'h0000_0ACE, 0, 4'h0, 0, 8'h00, 1, "R9");

      repeat (4) step(1'b1, 4'hF);
      chk(q_we.size() == 0, "R5", "requests left in scoreboard", q_we.size(), 0);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule